// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Output Mode

This block is a first-in first-out buffer whose write side and read side run on clocks that have no relation to each other. Words go into an inferred dual-port RAM of `1 << AW` entries, each `W` bits wide. The write pointer and the read pointer cross between the two domains as Gray code. A full condition is worked out on the write side and an empty condition on the read side. Each pointer carries one wrap bit above the address.

The output timing mode is taken from `mode_sel` while the master reset is held, and `mode_sel` has no effect after that.

- **Standard mode:** a word reaches `rd_data` only when the reader asks for it. The two flag pins then mean empty and full, both active low.
- **Fall-through mode:** the oldest stored word moves into the output register by itself. The flag pins then mean output-ready and input-ready, both active low, so a high level means not ready.

A rewind input returns the read pointer to location zero so that stored data can be read again. While the rewind takes effect, the empty / not-ready indication is forced for `RT_HOLD` read clocks. A partial reset clears both pointers and the output register but keeps the mode that was latched.

Top module: `dual_clk_fifo`

## Requirements
- R1: In standard mode, every rising `rd_clk` edge with `rd_en_n` low and data stored loads the oldest word into `rd_data`. Words come out in the order they were written.
- R2: In standard mode, `empty_flag` is 0 when no word is stored and 1 otherwise. `full_flag` is 0 when `1<<AW` words are stored and 1 otherwise.
- R3: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` with `rd_en_n` held high, and `empty_flag` goes to 0. That word stays on `rd_data` until a read edge with `rd_en_n` low replaces it with the next word.
- R4: In fall-through mode, `full_flag` is 0 while the RAM has space and 1 once it holds `1<<AW` words. Together with the output register, the FIFO then holds `(1<<AW)+1` words.
- R5: The mode is the level on `mode_sel` while `mrst_n` is low: 0 selects standard, 1 selects fall-through. Changes on `mode_sel` at any other time have no effect.
- R6: A write while full and a read while empty are ignored. Neither pointer moves, and `rd_data` does not change.
- R7: `rewind_n` low on a rising `rd_clk` edge sets the read pointer to location zero and leaves the write pointer unchanged. Later reads return the words from location zero onward, and new writes still append after the last stored word.
- R8: After a rewind edge, `empty_flag` shows empty (0 in standard mode, 1 in fall-through mode) for `RT_HOLD` read clocks. It then follows the pointers again.
- R9: `mrst_n` low clears both pointers and `rd_data` to all zeros, which leaves the FIFO empty.
- R10: `prst_n` low clears both pointers and `rd_data` to all zeros and keeps the mode latched at the last master reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, keeps the mode |
| mode_sel | input | 1 | Mode chosen during master reset (1 = fall-through) |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | W | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| rewind_n | input | 1 | Retransmit, active low, sampled on `rd_clk` |
| rd_data | output | W | Output register |
| empty_flag | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| full_flag | output | 1 | Full (standard) or input-ready (fall-through), active low |

## Verification
The bench sweeps every fill level from one word up to capacity in both modes and reads each word back against an arithmetic pattern.

- **Pointer wrap:** a design with a faulty wrap bit would either report full at the wrong count or return stale words.
- **Overrun and underrun:** writes to a full FIFO and reads from an empty one must leave no trace. A design that advances a pointer anyway would duplicate or drop a word on the next read.
- **Retransmit:** the bench counts the forced-empty window clock by clock and then expects the word from location zero. It also appends one more word to confirm the write pointer was left alone.
- **Mode latching:** the bench toggles `mode_sel` outside the master reset and issues a partial reset with the opposite level. A design that relatched the mode would show a flag of the wrong polarity, or a word falling through in standard mode.

// File: rtl/dual_clk_fifo_pkg.sv
`timescale 1ns/1ps
package dual_clk_fifo_pkg;

  // Output timing mode, captured while the master reset is held
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/dual_clk_fifo_rst_sync.sv
`timescale 1ns/1ps
// Asserts asynchronously, releases after STAGES edges of clk
module dual_clk_fifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = shift_q[STAGES-1];
endmodule

// File: rtl/dual_clk_fifo_ptr_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a Gray-coded pointer
module dual_clk_fifo_ptr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dual_clk_fifo_ram.sv
`timescale 1ns/1ps
// Storage: one synchronous write port, one combinational read port
module dual_clk_fifo_ram #(
  parameter int W  = 18,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          wr_ce,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_word,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_ce) mem[wr_addr] <= wr_word;
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/dual_clk_fifo_wr_ctl.sv
`timescale 1ns/1ps
module dual_clk_fifo_wr_ctl
  import dual_clk_fifo_pkg::*;
#(
  parameter int AW          = 4,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic        wr_clk,
  input  logic        wr_rst_n,
  input  logic        wr_mrst_n,
  input  logic        mode_sel,
  input  logic        wr_en_n,
  input  logic [AW:0] rd_gray_in,
  output logic [AW:0] wr_gray,
  output logic [AW:0] wr_ptr,
  output logic [AW-1:0] wr_addr,
  output logic        wr_ce,
  output logic        full_flag,
  output fifo_mode_e  mode
);
  // The two top bits differ when the pointers are one lap apart
  localparam logic [AW:0] LAP_MASK = {2'b11, {(AW-1){1'b0}}};
  localparam logic [AW:0] ONE      = 1;

  logic [AW:0] rd_gray_s;
  logic [AW:0] ptr_q, ptr_d;
  logic [AW:0] gray_q, gray_d;
  logic        full;
  fifo_mode_e  mode_q;

  dual_clk_fifo_ptr_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_rsync (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rd_gray_in),
    .q     (rd_gray_s)
  );

  // Mode follows the pin only while master reset is held
  always_ff @(posedge wr_clk) begin
    if (!wr_mrst_n) mode_q <= fifo_mode_e'(mode_sel);
  end

  assign full  = (gray_q == (rd_gray_s ^ LAP_MASK));
  assign wr_ce = !wr_en_n && !full;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_ce) ptr_d = ptr_q + ONE;
    gray_d = ptr_d ^ (ptr_d >> 1);
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      ptr_q  <= '0;
      gray_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      gray_q <= gray_d;
    end
  end

  assign full_flag = (mode_q == MODE_FWFT) ? full : !full;
  assign wr_gray   = gray_q;
  assign wr_ptr    = ptr_q;
  assign wr_addr   = ptr_q[AW-1:0];
  assign mode      = mode_q;
endmodule

// File: rtl/dual_clk_fifo_rd_ctl.sv
`timescale 1ns/1ps
module dual_clk_fifo_rd_ctl
  import dual_clk_fifo_pkg::*;
#(
  parameter int W           = 18,
  parameter int AW          = 4,
  parameter int RT_HOLD     = 4,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_mrst_n,
  input  logic          mode_sel,
  input  logic          rd_en_n,
  input  logic          rewind_n,
  input  logic [AW:0]   wr_gray_in,
  input  logic [W-1:0]  mem_word,
  output logic [AW:0]   rd_gray,
  output logic [AW:0]   rd_ptr,
  output logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          empty_flag,
  output fifo_mode_e    mode
);
  localparam int HW = $clog2(RT_HOLD + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(RT_HOLD);
  localparam logic [HW-1:0] HOLD_ONE  = 1;
  localparam logic [AW:0]   ONE       = 1;

  logic [AW:0]   wr_gray_s;
  logic [AW:0]   ptr_q, ptr_d;
  logic [AW:0]   gray_q, gray_d;
  logic [W-1:0]  data_q, data_d;
  logic          vld_q, vld_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          mem_empty, holding, avail, take, load;
  fifo_mode_e    mode_q;

  dual_clk_fifo_ptr_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_wsync (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wr_gray_in),
    .q     (wr_gray_s)
  );

  always_ff @(posedge rd_clk) begin
    if (!rd_mrst_n) mode_q <= fifo_mode_e'(mode_sel);
  end

  assign mem_empty = (gray_q == wr_gray_s);
  assign holding   = (hold_q != '0);
  assign avail     = !mem_empty && !holding;

  // Fall-through: consumer takes the held word; standard: consumer pulls one
  assign take = !rd_en_n && vld_q && !holding;
  assign load = (mode_q == MODE_FWFT) ? (avail && (!vld_q || take))
                                      : (avail && !rd_en_n);

  always_comb begin
    ptr_d  = ptr_q;
    data_d = data_q;
    vld_d  = vld_q;
    hold_d = holding ? (hold_q - HOLD_ONE) : hold_q;
    if (!rewind_n) begin
      ptr_d  = '0;
      vld_d  = 1'b0;
      hold_d = HOLD_INIT;
    end else begin
      if (load) begin
        ptr_d  = ptr_q + ONE;
        data_d = mem_word;
      end
      if (mode_q == MODE_FWFT) begin
        if (load)      vld_d = 1'b1;
        else if (take) vld_d = 1'b0;
      end
    end
    gray_d = ptr_d ^ (ptr_d >> 1);
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      ptr_q  <= '0;
      gray_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      gray_q <= gray_d;
      data_q <= data_d;
      vld_q  <= vld_d;
      hold_q <= hold_d;
    end
  end

  assign empty_flag = (mode_q == MODE_FWFT) ? !vld_q : !(mem_empty || holding);
  assign rd_gray    = gray_q;
  assign rd_ptr     = ptr_q;
  assign rd_addr    = ptr_q[AW-1:0];
  assign rd_data    = data_q;
  assign mode       = mode_q;
endmodule

// File: rtl/dual_clk_fifo.sv
`timescale 1ns/1ps
module dual_clk_fifo
  import dual_clk_fifo_pkg::*;
#(
  parameter int W           = 18,
  parameter int AW          = 4,
  parameter int RT_HOLD     = 4,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         mode_sel,
  input  logic         wr_en_n,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en_n,
  input  logic         rewind_n,
  output logic [W-1:0] rd_data,
  output logic         empty_flag,
  output logic         full_flag
);
  localparam int NDOM = 2;  // index 0: write side, 1: read side

  logic [NDOM-1:0] dom_clk, dom_rst_n, dom_mrst_n;
  logic            any_rst_n;
  logic            wr_rst_n, rd_rst_n;
  logic [AW:0]     wr_gray, rd_gray, wr_ptr, rd_ptr;
  logic [AW-1:0]   wr_addr, rd_addr;
  logic            wr_ce;
  logic [W-1:0]    mem_word;
  fifo_mode_e      wr_mode, rd_mode;
  logic            wr_mode_ft, rd_mode_ft;

  assign dom_clk   = {rd_clk, wr_clk};
  assign any_rst_n = mrst_n & prst_n;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    dual_clk_fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_any (
      .clk    (dom_clk[d]),
      .arst_n (any_rst_n),
      .rst_n  (dom_rst_n[d])
    );
    dual_clk_fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_mst (
      .clk    (dom_clk[d]),
      .arst_n (mrst_n),
      .rst_n  (dom_mrst_n[d])
    );
  end

  assign wr_rst_n = dom_rst_n[0];
  assign rd_rst_n = dom_rst_n[1];

  dual_clk_fifo_wr_ctl #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .wr_clk     (wr_clk),
    .wr_rst_n   (wr_rst_n),
    .wr_mrst_n  (dom_mrst_n[0]),
    .mode_sel   (mode_sel),
    .wr_en_n    (wr_en_n),
    .rd_gray_in (rd_gray),
    .wr_gray    (wr_gray),
    .wr_ptr     (wr_ptr),
    .wr_addr    (wr_addr),
    .wr_ce      (wr_ce),
    .full_flag  (full_flag),
    .mode       (wr_mode)
  );

  dual_clk_fifo_ram #(.W(W), .AW(AW)) u_ram (
    .wr_clk  (wr_clk),
    .wr_ce   (wr_ce),
    .wr_addr (wr_addr),
    .wr_word (wr_data),
    .rd_addr (rd_addr),
    .rd_word (mem_word)
  );

  dual_clk_fifo_rd_ctl #(
    .W(W), .AW(AW), .RT_HOLD(RT_HOLD), .SYNC_STAGES(SYNC_STAGES)
  ) u_rd (
    .rd_clk     (rd_clk),
    .rd_rst_n   (rd_rst_n),
    .rd_mrst_n  (dom_mrst_n[1]),
    .mode_sel   (mode_sel),
    .rd_en_n    (rd_en_n),
    .rewind_n   (rewind_n),
    .wr_gray_in (wr_gray),
    .mem_word   (mem_word),
    .rd_gray    (rd_gray),
    .rd_ptr     (rd_ptr),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .empty_flag (empty_flag),
    .mode       (rd_mode)
  );

  assign wr_mode_ft = (wr_mode == MODE_FWFT);
  assign rd_mode_ft = (rd_mode == MODE_FWFT);
endmodule

// File: rtl/dual_clk_fifo_chk.sv
`timescale 1ns/1ps
module dual_clk_fifo_chk #(
  parameter int W  = 18,
  parameter int AW = 4
) (
  input logic         wr_clk,
  input logic         rd_clk,
  input logic         wr_rst_n,
  input logic         rd_rst_n,
  input logic         wr_mode_ft,
  input logic         rd_mode_ft,
  input logic         wr_en_n,
  input logic         rd_en_n,
  input logic         rewind_n,
  input logic         empty_flag,
  input logic         full_flag,
  input logic [AW:0]  wr_ptr,
  input logic [AW:0]  rd_ptr,
  input logic [W-1:0] rd_data
);
  // R6
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    ((full_flag == wr_mode_ft) && !wr_en_n) |=> $stable(wr_ptr));

  // R6
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!rd_mode_ft && !empty_flag && rewind_n) |=> ($stable(rd_ptr) && $stable(rd_data)));

  // R3
  fwft_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_mode_ft && !empty_flag && rd_en_n && rewind_n) |=> ($stable(rd_data) && !empty_flag));

  // R7
  rewind_ptr_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rewind_n |=> (rd_ptr == '0));

  // R8
  rewind_flag_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rewind_n |=> (empty_flag == rd_mode_ft));

  // R5
  rd_mode_keep_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    1'b1 |=> $stable(rd_mode_ft));

  // R5
  wr_mode_keep_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    1'b1 |=> $stable(wr_mode_ft));
endmodule

bind dual_clk_fifo dual_clk_fifo_chk #(.W(W), .AW(AW)) chk_i (
  .wr_clk     (wr_clk),
  .rd_clk     (rd_clk),
  .wr_rst_n   (wr_rst_n),
  .rd_rst_n   (rd_rst_n),
  .wr_mode_ft (wr_mode_ft),
  .rd_mode_ft (rd_mode_ft),
  .wr_en_n    (wr_en_n),
  .rd_en_n    (rd_en_n),
  .rewind_n   (rewind_n),
  .empty_flag (empty_flag),
  .full_flag  (full_flag),
  .wr_ptr     (wr_ptr),
  .rd_ptr     (rd_ptr),
  .rd_data    (rd_data)
);

// File: tb/dual_clk_fifo_tb_top.sv
`timescale 1ns/1ps
module dual_clk_fifo_tb_top;
  localparam int W     = 8;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int HOLD  = 4;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic mrst_n, prst_n, mode_sel, wr_en_n, rd_en_n, rewind_n;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic empty_flag, full_flag;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 wr_clk = ~wr_clk;  // 250 MHz write clock
  always #3 rd_clk = ~rd_clk;  // unrelated read clock

  dual_clk_fifo #(.W(W), .AW(AW), .RT_HOLD(HOLD)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_sel(mode_sel), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_en_n(rd_en_n), .rewind_n(rewind_n), .rd_data(rd_data),
    .empty_flag(empty_flag), .full_flag(full_flag)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int i, input int s);
    return W'(i * 53 + s * 29 + 17);
  endfunction

  task automatic wr_word(input logic [W-1:0] v);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = v;
    @(posedge wr_clk);
    #1 wr_en_n = 1'b1;
  endtask

  // One read edge; returns rd_data sampled after it
  task automatic rd_pulse(output logic [W-1:0] v);
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    @(posedge rd_clk);
    #1 rd_en_n = 1'b1;
    @(negedge rd_clk);
    v = rd_data;
  endtask

  task automatic settle();
    repeat (12) @(negedge rd_clk);
  endtask

  task automatic master_reset(input logic m);
    mrst_n = 1'b0;
    mode_sel = m;
    repeat (4) @(negedge rd_clk);
    mrst_n = 1'b1;
    repeat (6) @(negedge rd_clk);
    mode_sel = ~m;  // must now be ignored
    settle();
  endtask

  task automatic partial_reset(input logic m);
    prst_n = 1'b0;
    mode_sel = m;
    repeat (4) @(negedge rd_clk);
    prst_n = 1'b1;
    repeat (6) @(negedge rd_clk);
    mode_sel = ~m;
    settle();
  endtask

  task automatic rewind();
    @(negedge rd_clk);
    rewind_n = 1'b0;
    @(posedge rd_clk);
    #1 rewind_n = 1'b1;
  endtask

  initial begin
    logic [W-1:0] got;
    mrst_n = 1'b1; prst_n = 1'b1; mode_sel = 1'b0;
    wr_en_n = 1'b1; rd_en_n = 1'b1; rewind_n = 1'b1; wr_data = '0;
    #1;

    // ---------------- standard mode ----------------
    master_reset(1'b0);
    chk("R9 rd_data after master reset", rd_data, 0);
    chk("R2 empty flag after reset", empty_flag, 0);
    chk("R2 full flag after reset", full_flag, 1);

    // mode_sel is now 1: nothing must fall through
    wr_word(8'h3C);
    settle();
    chk("R5 no fall-through in standard", rd_data, 0);
    rd_pulse(got);
    chk("R1 single word", got, 8'h3C);

    // sweep every fill level
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) wr_word(pat(i, n));
      settle();
      chk("R2 not empty with data", empty_flag, 1);
      chk("R2 full flag level", full_flag, (n == DEPTH) ? 0 : 1);
      if (n == DEPTH) begin
        wr_word(8'hEE);
        wr_word(8'hEF);
        settle();
      end
      for (int i = 0; i < n; i++) begin
        rd_pulse(got);
        chk("R1 order", got, pat(i, n));
      end
      settle();
      chk("R2 empty after drain", empty_flag, 0);
    end

    // read while empty is ignored
    rd_pulse(got);
    chk("R6 read on empty keeps data", got, pat(DEPTH - 1, DEPTH));
    wr_word(8'hA5);
    settle();
    rd_pulse(got);
    chk("R6 pointer unmoved by empty read", got, 8'hA5);

    // partial reset keeps standard mode
    partial_reset(1'b1);
    chk("R10 rd_data cleared", rd_data, 0);
    chk("R10 standard empty polarity kept", empty_flag, 0);

    // retransmit in standard mode
    for (int i = 0; i < 5; i++) wr_word(pat(i, 40));
    settle();
    for (int i = 0; i < 3; i++) begin
      rd_pulse(got);
      chk("R1 before rewind", got, pat(i, 40));
    end
    rewind();
    for (int j = 0; j < HOLD; j++) begin
      @(negedge rd_clk);
      chk("R8 forced empty (standard)", empty_flag, 0);
    end
    @(negedge rd_clk);
    chk("R8 flag recovers", empty_flag, 1);
    for (int i = 0; i < 5; i++) begin
      rd_pulse(got);
      chk("R7 reread from zero", got, pat(i, 40));
    end
    wr_word(8'h77);
    settle();
    rd_pulse(got);
    chk("R7 write pointer kept", got, 8'h77);

    // ---------------- fall-through mode ----------------
    master_reset(1'b1);
    chk("R9 rd_data after master reset", rd_data, 0);
    chk("R3 not ready when empty", empty_flag, 1);
    chk("R4 input ready when empty", full_flag, 0);

    for (int n = 1; n <= DEPTH + 1; n++) begin
      wr_word(pat(0, n + 60));
      settle();
      for (int i = 1; i < n; i++) wr_word(pat(i, n + 60));
      settle();
      chk("R4 full at capacity", full_flag, (n == DEPTH + 1) ? 1 : 0);
      if (n == DEPTH + 1) begin
        wr_word(8'hEE);
        settle();
      end
      for (int i = 0; i < n; i++) begin
        chk("R3 ready with word", empty_flag, 0);
        chk("R3 word without read", rd_data, pat(i, n + 60));
        rd_pulse(got);
        settle();
      end
      chk("R3 not ready after drain", empty_flag, 1);
      chk("R4 input ready after drain", full_flag, 0);
    end

    // partial reset with opposite pin keeps fall-through
    wr_word(8'h5A);
    settle();
    partial_reset(1'b0);
    chk("R10 rd_data cleared", rd_data, 0);
    chk("R10 fall-through polarity kept", empty_flag, 1);
    wr_word(8'h21);
    settle();
    chk("R10 still falls through", rd_data, 8'h21);

    // retransmit in fall-through mode
    partial_reset(1'b0);
    wr_word(pat(0, 90));
    settle();
    for (int i = 1; i < 4; i++) wr_word(pat(i, 90));
    settle();
    rd_pulse(got);
    rd_pulse(got);
    settle();
    chk("R3 third word shown", rd_data, pat(2, 90));
    rewind();
    for (int j = 0; j < HOLD; j++) begin
      @(negedge rd_clk);
      chk("R8 forced not-ready (fall-through)", empty_flag, 1);
    end
    settle();
    chk("R7 ready after rewind", empty_flag, 0);
    chk("R7 word zero returns", rd_data, pat(0, 90));
    rd_pulse(got);
    settle();
    chk("R7 word one follows", rd_data, pat(1, 90));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule